// File: doc/BRIEF.md
# Programmable Delay Tap Controller

This block holds the tap setting of one lane's programmable delay line as a plain tap number and lets fabric logic move it. A stage is 9 bits wide (512 taps, about 1.25 ns of delay). On each rising edge of the delay clock the block samples a step enable, a step direction and a load strobe. It reports the current setting on a count output. The analog delay elements, picosecond calibration and pad buffers are outside the block.

A parameter selects one of three behaviours: a frozen setting, step-only, or step-plus-load. A second parameter adds an extension stage behind the main one, which doubles the range to 1024 taps (about 2.5 ns). The extension stage has its own step, load and count ports. A delay-reset input returns both stages to their parameterised default. A voltage/temperature tracking enable blocks loads while it is high.

Top module: `dlyt_tap_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the main count becomes min(DEFAULT_TAP, 511). The extension count becomes the rest of DEFAULT_TAP, capped at 511, when cascade is on, and 0 when it is off.
- R2: With MODE = fixed (0), both counts stay at their defaults whatever `ce`, `inc` and `load` do.
- R3: In the step modes (1 = step-only, 2 = step-plus-load), `ce`=1 with `inc`=1 adds one tap and `ce`=1 with `inc`=0 removes one tap. The new count is visible on the output after the edge that sampled the command.
- R4: In step-only mode, `load` is ignored.
- R5: In step-plus-load mode, `load`=1 with `vt_track_en`=0 copies `cnt_in` into the main count.
- R6: While `vt_track_en`=1, a load is refused and the cycle behaves as if `load` were low, so a `ce` in that cycle still steps.
- R7: `rst_dly`=1 returns both counts to their defaults and overrides every other command in that cycle.
- R8: When an accepted load and `ce` arrive in the same cycle, the load wins and no step is applied.
- R9: A stage never wraps. An increment at 511 holds at 511 and a decrement at 0 holds at 0. In cascade, an increment with both stages at 511 holds both.
- R10: In cascade, a main-port increment with the main stage at 511 adds one tap to the extension stage. A main-port decrement removes a tap from the extension stage first and touches the main stage only when the extension count is 0.
- R11: The extension ports step and load the extension stage alone, under the same mode, tracking and priority rules. In a cycle where the extension port issues a command, that command owns the extension stage and a main-port step stays within the main stage.
- R12: Without cascade, `ext_cnt_out` is always 0 and the extension inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Delay clock; all commands sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_dly | input | 1 | Return both counts to default |
| vt_track_en | input | 1 | Tracking enable; loads refused while high |
| ce | input | 1 | Main-port step enable |
| inc | input | 1 | Main-port step direction, 1 = up |
| load | input | 1 | Main-port load strobe |
| cnt_in | input | 9 | Main-port load value |
| cnt_out | output | 9 | Main stage tap count |
| ext_ce | input | 1 | Extension-port step enable |
| ext_inc | input | 1 | Extension-port step direction, 1 = up |
| ext_load | input | 1 | Extension-port load strobe |
| ext_cnt_in | input | 9 | Extension-port load value |
| ext_cnt_out | output | 9 | Extension stage tap count |

## Verification
Three commands can fall in the same edge: a load, a step and, in cascade, a command on the extension port. The bench raises `load` and `ce` together with tracking off and expects the loaded value, not the loaded value plus one. It repeats the pair with tracking on and expects only the step. It also drives a main-port increment at tap 511 and a main-port decrement while an extension-port command is active. In those cases it expects the extension stage to follow only its own port and the main stage to step or saturate on its own.

// File: rtl/dlyt_pkg.sv
// Shared types for the delay tap controller.
// Assumes: modes and commands are small enums used by every submodule.
package dlyt_pkg;
    typedef enum logic [1:0] {
        MODE_FIXED     = 2'd0,
        MODE_STEP      = 2'd1,
        MODE_STEP_LOAD = 2'd2
    } dly_mode_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_UP   = 2'd1,
        CMD_DOWN = 2'd2,
        CMD_LOAD = 2'd3
    } dly_cmd_e;
endpackage

// File: rtl/dlyt_cmd_decode.sv
// Turns one port's raw strobes into a single stage command.
// Assumes: the strobes are already synchronous to the delay clock.
// The mode is fixed at elaboration time. A refused load falls through to the step.
module dlyt_cmd_decode
    import dlyt_pkg::*;
#(
    parameter dly_mode_e MODE = MODE_STEP_LOAD
) (
    input  logic     ce,
    input  logic     inc,
    input  logic     load,
    input  logic     vt_track_en,
    output dly_cmd_e cmd
);
    // Priority: frozen mode, then accepted load, then step.
    always_comb begin
        cmd = CMD_HOLD;
        if (MODE != MODE_FIXED) begin
            if (MODE == MODE_STEP_LOAD && load && !vt_track_en) begin
                cmd = CMD_LOAD;
            end else if (ce) begin
                cmd = inc ? CMD_UP : CMD_DOWN;
            end
        end
    end
endmodule

// File: rtl/dlyt_carry_route.sv
// Shares main-port steps between the main and extension stages in cascade.
// Assumes: requests come from dlyt_cmd_decode. Without cascade, the extension
// stage is held and the main request passes through untouched.
module dlyt_carry_route
    import dlyt_pkg::*;
#(
    parameter int TAP_W   = 9,
    parameter bit CASCADE = 1'b1
) (
    input  dly_cmd_e         main_req,
    input  dly_cmd_e         ext_req,
    input  logic [TAP_W-1:0] main_tap,
    input  logic [TAP_W-1:0] ext_tap,
    output dly_cmd_e         main_cmd,
    output dly_cmd_e         ext_cmd
);
    localparam logic [TAP_W-1:0] TAP_TOP = '1;

    // Carry up past a full main stage; borrow down from the extension first.
    always_comb begin
        main_cmd = main_req;
        ext_cmd  = CMD_HOLD;
        if (CASCADE) begin
            ext_cmd = ext_req;
            if (ext_req == CMD_HOLD) begin
                if (main_req == CMD_UP && main_tap == TAP_TOP && ext_tap != TAP_TOP) begin
                    ext_cmd = CMD_UP;
                end else if (main_req == CMD_DOWN && ext_tap != '0) begin
                    ext_cmd  = CMD_DOWN;
                    main_cmd = CMD_HOLD;
                end
            end
        end
    end
endmodule

// File: rtl/dlyt_stage.sv
// One saturating tap register of the delay line.
// Assumes: a single command per cycle. Delay reset beats the command.
module dlyt_stage
    import dlyt_pkg::*;
#(
    parameter int TAP_W   = 9,
    parameter int DEF_TAP = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_dly,
    input  dly_cmd_e         cmd,
    input  logic [TAP_W-1:0] cnt_in,
    output logic [TAP_W-1:0] tap
);
    localparam logic [TAP_W-1:0] TAP_TOP = '1;
    localparam logic [TAP_W-1:0] TAP_DEF = TAP_W'(DEF_TAP);

    // Tap register: reset, delay reset, load, or saturating step.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_dly) begin
            tap <= TAP_DEF;
        end else begin
            case (cmd)
                CMD_UP:   if (tap != TAP_TOP) tap <= tap + 1'b1;
                CMD_DOWN: if (tap != '0)      tap <= tap - 1'b1;
                CMD_LOAD: tap <= cnt_in;
                default:  ;
            endcase
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_UP && tap == TAP_TOP && !rst_dly) |=> tap == TAP_TOP);
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DOWN && tap == '0 && !rst_dly) |=> tap == '0);
    assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_UP && tap != TAP_TOP && !rst_dly) |=> tap == $past(tap) + 1'b1);
    assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD && !rst_dly) |=> tap == $past(cnt_in));
    assert_back_to_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_dly |=> tap == TAP_DEF);
endmodule

// File: rtl/dlyt_tap_ctrl.sv
// Top of the delay tap controller: decodes both ports, routes carries and
// holds the main and extension tap registers.
// Assumes: all inputs synchronous to clk. DEFAULT_TAP counts total taps.
module dlyt_tap_ctrl
    import dlyt_pkg::*;
#(
    parameter int        TAP_W       = 9,
    parameter dly_mode_e MODE        = MODE_STEP_LOAD,
    parameter bit        CASCADE     = 1'b1,
    parameter int        DEFAULT_TAP = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_dly,
    input  logic             vt_track_en,
    input  logic             ce,
    input  logic             inc,
    input  logic             load,
    input  logic [TAP_W-1:0] cnt_in,
    output logic [TAP_W-1:0] cnt_out,
    input  logic             ext_ce,
    input  logic             ext_inc,
    input  logic             ext_load,
    input  logic [TAP_W-1:0] ext_cnt_in,
    output logic [TAP_W-1:0] ext_cnt_out
);
    localparam int STAGE_MAX = (1 << TAP_W) - 1;
    localparam int MAIN_DEF  = (DEFAULT_TAP > STAGE_MAX) ? STAGE_MAX : DEFAULT_TAP;
    localparam int EXT_REST  = DEFAULT_TAP - MAIN_DEF;
    localparam int EXT_DEF   = !CASCADE ? 0 : ((EXT_REST > STAGE_MAX) ? STAGE_MAX : EXT_REST);
    localparam logic [TAP_W-1:0] TAP_TOP = '1;

    dly_cmd_e main_req, ext_req, main_cmd, ext_cmd;

    dlyt_cmd_decode #(.MODE(MODE)) u_main_dec (
        .ce(ce), .inc(inc), .load(load), .vt_track_en(vt_track_en), .cmd(main_req));

    dlyt_cmd_decode #(.MODE(MODE)) u_ext_dec (
        .ce(ext_ce), .inc(ext_inc), .load(ext_load), .vt_track_en(vt_track_en), .cmd(ext_req));

    dlyt_carry_route #(.TAP_W(TAP_W), .CASCADE(CASCADE)) u_route (
        .main_req(main_req), .ext_req(ext_req), .main_tap(cnt_out), .ext_tap(ext_cnt_out),
        .main_cmd(main_cmd), .ext_cmd(ext_cmd));

    dlyt_stage #(.TAP_W(TAP_W), .DEF_TAP(MAIN_DEF)) u_main_stage (
        .clk(clk), .rst_n(rst_n), .rst_dly(rst_dly), .cmd(main_cmd),
        .cnt_in(cnt_in), .tap(cnt_out));

    dlyt_stage #(.TAP_W(TAP_W), .DEF_TAP(EXT_DEF)) u_ext_stage (
        .clk(clk), .rst_n(rst_n), .rst_dly(rst_dly), .cmd(ext_cmd),
        .cnt_in(ext_cnt_in), .tap(ext_cnt_out));

    assert_fixed_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_FIXED) |-> (cnt_out == TAP_W'(MAIN_DEF) && ext_cnt_out == TAP_W'(EXT_DEF)));
    assert_vt_refuses_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vt_track_en && load && !ce && !rst_dly) |=> $stable(cnt_out));
    assert_load_beats_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_STEP_LOAD && load && ce && !vt_track_en && !rst_dly) |=> cnt_out == $past(cnt_in));
    assert_carry_into_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (CASCADE && main_req == CMD_UP && cnt_out == TAP_TOP && ext_req == CMD_HOLD
         && ext_cnt_out != TAP_TOP && !rst_dly) |=> ext_cnt_out == $past(ext_cnt_out) + 1'b1);
    assert_no_ext_without_cascade_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !CASCADE |-> ext_cnt_out == '0);
endmodule

// File: tb/tb_dlyt_tap_ctrl.sv
`timescale 1ns/1ps
module tb_dlyt_tap_ctrl;
    import dlyt_pkg::*;

    logic clk = 1'b0;
    logic rst_n, rst_dly, vt, ce, inc, load, ece, einc, eload;
    logic [8:0] cin, ecin;
    logic [8:0] m_out, e_out, s_out, se_out, f_out, fe_out;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dlyt_tap_ctrl #(.MODE(MODE_STEP_LOAD), .CASCADE(1'b1), .DEFAULT_TAP(100)) dut (
        .clk(clk), .rst_n(rst_n), .rst_dly(rst_dly), .vt_track_en(vt), .ce(ce), .inc(inc),
        .load(load), .cnt_in(cin), .cnt_out(m_out), .ext_ce(ece), .ext_inc(einc),
        .ext_load(eload), .ext_cnt_in(ecin), .ext_cnt_out(e_out));

    dlyt_tap_ctrl #(.MODE(MODE_STEP), .CASCADE(1'b0), .DEFAULT_TAP(5)) dut_step (
        .clk(clk), .rst_n(rst_n), .rst_dly(rst_dly), .vt_track_en(vt), .ce(ce), .inc(inc),
        .load(load), .cnt_in(cin), .cnt_out(s_out), .ext_ce(ece), .ext_inc(einc),
        .ext_load(eload), .ext_cnt_in(ecin), .ext_cnt_out(se_out));

    dlyt_tap_ctrl #(.MODE(MODE_FIXED), .CASCADE(1'b1), .DEFAULT_TAP(37)) dut_fix (
        .clk(clk), .rst_n(rst_n), .rst_dly(rst_dly), .vt_track_en(vt), .ce(ce), .inc(inc),
        .load(load), .cnt_in(cin), .cnt_out(f_out), .ext_ce(ece), .ext_inc(einc),
        .ext_load(eload), .ext_cnt_in(ecin), .ext_cnt_out(fe_out));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        rst_dly = 0; vt = 0; ce = 0; inc = 0; load = 0; cin = '0;
        ece = 0; einc = 0; eload = 0; ecin = '0;
    endtask

    // Drive one command cycle from a negedge and return at the next negedge.
    task automatic cyc(input logic c, input logic i, input logic l, input int v,
                       input logic ec, input logic ei, input logic el, input int ev,
                       input logic t);
        ce = c; inc = i; load = l; cin = 9'(v);
        ece = ec; einc = ei; eload = el; ecin = 9'(ev); vt = t;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        chk("R1 main default", m_out, 100);
        chk("R1 ext default", e_out, 0);
        chk("R1 step default", s_out, 5);
        chk("R1 fixed default", f_out, 37);
    endtask

    task automatic t_steps();
        repeat (3) cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R3 up x3", m_out, 103);
        chk("R3 step-only up x3", s_out, 8);
        chk("R2 fixed ignores ce", f_out, 37);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R3 down", m_out, 102);
        chk("R3 step-only down", s_out, 7);
    endtask

    task automatic t_load();
        cyc(0, 0, 1, 200, 0, 0, 0, 0, 0);
        chk("R5 load", m_out, 200);
        chk("R4 step-only ignores load", s_out, 7);
        chk("R2 fixed ignores load", f_out, 37);
        cyc(0, 0, 1, 50, 0, 0, 0, 0, 1);
        chk("R6 load refused under tracking", m_out, 200);
        cyc(1, 1, 1, 50, 0, 0, 0, 0, 1);
        chk("R6 refused load lets step through", m_out, 201);
        chk("R6 step-only steps", s_out, 8);
    endtask

    task automatic t_priority();
        cyc(1, 1, 1, 300, 0, 0, 0, 0, 0);
        chk("R8 load beats step", m_out, 300);
        chk("R4 step-only steps despite load", s_out, 9);
    endtask

    task automatic t_cascade();
        cyc(0, 0, 1, 511, 0, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R10 carry main", m_out, 511);
        chk("R10 carry ext", e_out, 1);
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R10 carry ext 2", e_out, 2);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R10 borrow ext first", e_out, 1);
        chk("R10 main untouched", m_out, 511);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R10 ext drained", e_out, 0);
        chk("R10 then main", m_out, 510);
    endtask

    task automatic t_ext_port();
        repeat (2) cyc(0, 0, 0, 0, 1, 1, 0, 0, 0);
        chk("R11 ext step", e_out, 2);
        cyc(0, 0, 0, 0, 0, 0, 1, 7, 0);
        chk("R11 ext load", e_out, 7);
        cyc(0, 0, 0, 0, 0, 0, 1, 9, 1);
        chk("R11 ext load refused", e_out, 7);
        cyc(1, 1, 0, 0, 1, 0, 0, 0, 0);
        chk("R11 main up alongside", m_out, 511);
        chk("R11 ext down own", e_out, 6);
        cyc(1, 1, 0, 0, 1, 1, 0, 0, 0);
        chk("R11 no carry when ext busy main", m_out, 511);
        chk("R11 no carry when ext busy ext", e_out, 7);
        cyc(1, 0, 0, 0, 1, 1, 0, 0, 0);
        chk("R11 main down no borrow", m_out, 510);
        chk("R11 ext up own", e_out, 8);
        chk("R12 no-cascade ext stays 0", se_out, 0);
        chk("R2 fixed ext frozen", fe_out, 0);
    endtask

    task automatic t_saturate();
        cyc(0, 0, 0, 0, 0, 0, 1, 511, 0);
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R9 both full main", m_out, 511);
        chk("R9 both full ext", e_out, 511);
        repeat (15) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R9 step-only floor", s_out, 0);
        chk("R10 ext drains", e_out, 496);
    endtask

    task automatic t_rst_dly();
        rst_dly = 1;
        cyc(1, 1, 1, 12, 1, 1, 1, 12, 0);
        chk("R7 main default", m_out, 100);
        chk("R7 ext default", e_out, 0);
        chk("R7 step default", s_out, 5);
        chk("R7 fixed default", f_out, 37);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_steps();
        t_load();
        t_priority();
        t_cascade();
        t_ext_port();
        t_saturate();
        t_rst_dly();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule